// File: doc/BRIEF.md
# Phase Offset Target with Incremental Stepping

This block holds the closed-loop phase offset target that a digital PLL's phase detector path steers toward. The target has two parts that never touch each other: a signed fixed offset loaded as one word, and an incremental offset that moves by a programmable unsigned step. The block presents the sum of the two parts, in picoseconds, as a single signed word.

The incremental part responds to three commands: step up, step down and clear. A command arrives either as a bit written to a self-clearing command register or as a single-cycle pulse on a dedicated pin. Both sources feed the same pending-command latch, so a command takes the same path whichever way it comes in. The incremental accumulator saturates at its limits rather than wrapping. Simultaneous up and down commands cancel each other. Clear overrides both.

Top module: `phase_offset_target`

## Requirements
- R1: After reset the fixed offset, the step size, the incremental offset, the pending command bits and the total output are all zero.
- R2: A fixed-offset write loads a FIX_W-bit (default 40) two's complement value in picoseconds. The new value appears in the total on the cycle after the write edge.
- R3: A step-up command adds the current unsigned STEP_W-bit (default 16) step size to the incremental offset.
- R4: Command bit 0 is step up, bit 1 is step down and bit 2 is clear. A command written at one clock edge is pending after that edge. It is executed at the next edge, and its pending bit reads zero afterwards unless a new command was written or pulsed.
- R5: A step-down command subtracts the current step size from the incremental offset.
- R6: A clear command sets the incremental offset to zero and leaves the fixed offset unchanged.
- R7: Writing the fixed offset or the step size never changes the incremental offset. Commands never change the fixed offset.
- R8: A high level on the up, down or clear pin during a cycle has the same effect and the same latency as writing that command bit in that cycle. The pins and register writes are ORed together.
- R9: When step up and step down are pending together, the incremental offset is unchanged. When clear is pending, it wins over both.
- R10: The ACC_W-bit signed incremental offset saturates at its most positive and most negative values instead of wrapping.
- R11: The total output equals the fixed offset plus the incremental offset, exactly, in a signed word one bit wider than the wider of the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fixedWrEn | input | 1 | Load the fixed offset |
| fixedWrData | input | FIX_W | Signed fixed offset in ps |
| stepWrEn | input | 1 | Load the step size |
| stepWrData | input | STEP_W | Unsigned step size in ps |
| cmdWrEn | input | 1 | Write the command bits |
| cmdWrData | input | 3 | Bit 0 up, bit 1 down, bit 2 clear |
| pinUp | input | 1 | Step-up pin |
| pinDown | input | 1 | Step-down pin |
| pinClear | input | 1 | Clear pin |
| cmdPending | output | 3 | Self-clearing command bits, readable |
| incOffset | output | ACC_W | Signed incremental offset in ps |
| totalOffset | output | max(FIX_W,ACC_W)+1 | Signed total offset in ps |

## Verification
The bench instantiates the block with a narrowed 20-bit accumulator so that a handful of full-size steps reach both saturation limits. A design that wrapped would jump from the top limit to a large negative value. Collisions of up and down, and of clear with either, are driven on purpose: a design with the wrong priority would move the offset by one step where it must hold or zero it. Pin pulses and register writes in the same cycle are mixed to catch a missing OR or an extra cycle of latency on one path. Fixed writes during stepping expose any coupling between the two offset parts.

// File: rtl/phase_offset_pkg.sv
package phase_offset_pkg;
  // Decoded strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic down;
    logic up;
  } offStrobe_t;

  localparam int CMD_UP    = 0;
  localparam int CMD_DOWN  = 1;
  localparam int CMD_CLEAR = 2;
endpackage

// File: rtl/po_cmd_ctrl.sv
module po_cmd_ctrl
  import phase_offset_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWrEn,
  input  logic [2:0] cmdWrData,
  input  logic       pinUp,
  input  logic       pinDown,
  input  logic       pinClear,
  output logic [2:0] cmdPending,
  output offStrobe_t strobe
);
  logic [2:0] cmdReq;

  always_comb begin
    cmdReq = cmdWrEn ? cmdWrData : 3'b000;
    cmdReq[CMD_UP]    = cmdReq[CMD_UP]    | pinUp;
    cmdReq[CMD_DOWN]  = cmdReq[CMD_DOWN]  | pinDown;
    cmdReq[CMD_CLEAR] = cmdReq[CMD_CLEAR] | pinClear;
  end

  // Pending bits hold for exactly one cycle, then self-clear
  always_ff @(posedge clk) begin
    if (!rstN) cmdPending <= '0;
    else       cmdPending <= cmdReq;
  end

  assign strobe.up    = cmdPending[CMD_UP];
  assign strobe.down  = cmdPending[CMD_DOWN];
  assign strobe.clear = cmdPending[CMD_CLEAR];

  AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (cmdPending != 3'b000 && !cmdWrEn && !pinUp && !pinDown && !pinClear) |=> (cmdPending == 3'b000)); // R4

  AST_PIN_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    pinClear |=> cmdPending[CMD_CLEAR]); // R8
endmodule

// File: rtl/po_offset_dp.sv
module po_offset_dp
  import phase_offset_pkg::*;
#(
  parameter int FIX_W  = 40,
  parameter int STEP_W = 16,
  parameter int ACC_W  = 40,
  localparam int TOT_W = ((FIX_W > ACC_W) ? FIX_W : ACC_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  offStrobe_t        strobe,
  input  logic              fixedWrEn,
  input  logic [FIX_W-1:0]  fixedWrData,
  input  logic              stepWrEn,
  input  logic [STEP_W-1:0] stepWrData,
  output logic [ACC_W-1:0]  incOffset,
  output logic [TOT_W-1:0]  totalOffset
);
  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic [FIX_W-1:0]  fixedReg;
  logic [STEP_W-1:0] stepReg;
  logic [ACC_W-1:0]  accReg;
  logic [ACC_W:0]    accWide, stepWide, sumUp, sumDown;
  logic [ACC_W-1:0]  accUp, accDown, accNext;

  always_comb begin
    accWide  = {accReg[ACC_W-1], accReg};
    stepWide = {{(ACC_W+1-STEP_W){1'b0}}, stepReg};
    sumUp    = accWide + stepWide;
    sumDown  = accWide - stepWide;
    // Overflow when the two top bits of the widened result disagree
    accUp    = (sumUp[ACC_W] != sumUp[ACC_W-1])     ? ACC_MAX : sumUp[ACC_W-1:0];
    accDown  = (sumDown[ACC_W] != sumDown[ACC_W-1]) ? ACC_MIN : sumDown[ACC_W-1:0];
    if (strobe.clear)                    accNext = '0;
    else if (strobe.up && !strobe.down)  accNext = accUp;
    else if (strobe.down && !strobe.up)  accNext = accDown;
    else                                 accNext = accReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fixedReg <= '0;
      stepReg  <= '0;
      accReg   <= '0;
    end else begin
      if (fixedWrEn) fixedReg <= fixedWrData;
      if (stepWrEn)  stepReg  <= stepWrData;
      accReg <= accNext;
    end
  end

  assign incOffset   = accReg;
  assign totalOffset = TOT_W'($signed(fixedReg)) + TOT_W'($signed(accReg));

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (incOffset == '0)); // R6

  AST_CANCEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && strobe.up && strobe.down) |=> $stable(incOffset)); // R9

  AST_FIXED_ISOLATED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0) |=> $stable(incOffset)); // R7

  AST_CMD_KEEPS_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (!fixedWrEn && strobe != '0) |=> $stable(fixedReg)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (incOffset == ACC_MAX && strobe.up && !strobe.down && !strobe.clear) |=> (incOffset == ACC_MAX)); // R10

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (incOffset == ACC_MIN && strobe.down && !strobe.up && !strobe.clear) |=> (incOffset == ACC_MIN)); // R10
endmodule

// File: rtl/phase_offset_target.sv
module phase_offset_target
  import phase_offset_pkg::*;
#(
  parameter int FIX_W  = 40,
  parameter int STEP_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fixedWrEn,
  input  logic [FIX_W-1:0]  fixedWrData,
  input  logic              stepWrEn,
  input  logic [STEP_W-1:0] stepWrData,
  input  logic              cmdWrEn,
  input  logic [2:0]        cmdWrData,
  input  logic              pinUp,
  input  logic              pinDown,
  input  logic              pinClear,
  output logic [2:0]        cmdPending,
  output logic [ACC_W-1:0]  incOffset,
  output logic [((FIX_W > ACC_W) ? FIX_W : ACC_W):0] totalOffset
);
  offStrobe_t strobe;

  po_cmd_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .pinUp(pinUp), .pinDown(pinDown), .pinClear(pinClear),
    .cmdPending(cmdPending), .strobe(strobe)
  );

  po_offset_dp #(.FIX_W(FIX_W), .STEP_W(STEP_W), .ACC_W(ACC_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .fixedWrEn(fixedWrEn), .fixedWrData(fixedWrData),
    .stepWrEn(stepWrEn), .stepWrData(stepWrData),
    .incOffset(incOffset), .totalOffset(totalOffset)
  );
endmodule

// File: tb/tb_phase_offset_target.sv
module tb_phase_offset_target;
  localparam int FIX_W = 40, STEP_W = 16, ACC_W = 20, TOT_W = 41;

  logic clk = 0, rstN = 0;
  logic fixedWrEn = 0, stepWrEn = 0, cmdWrEn = 0;
  logic [FIX_W-1:0] fixedWrData = '0;
  logic [STEP_W-1:0] stepWrData = '0;
  logic [2:0] cmdWrData = '0;
  logic pinUp = 0, pinDown = 0, pinClear = 0;
  logic [2:0] cmdPending;
  logic [ACC_W-1:0] incOffset;
  logic [TOT_W-1:0] totalOffset;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // Behavioural reference
  longint mFix = 0, mStep = 0, mAcc = 0;
  logic [2:0] mPend = 0;
  longint accHi = (longint'(1) <<< (ACC_W-1)) - 1;
  longint accLo = -(longint'(1) <<< (ACC_W-1));

  phase_offset_target #(.FIX_W(FIX_W), .STEP_W(STEP_W), .ACC_W(ACC_W)) dut (.*);

  always #10 clk = ~clk;

  function automatic longint clampAcc(longint v);
    if (v > accHi) return accHi;
    if (v < accLo) return accLo;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mFix <= 0; mStep <= 0; mAcc <= 0; mPend <= 0;
    end else begin
      if (mPend[2])                 mAcc <= 0;
      else if (mPend[0] && !mPend[1]) mAcc <= clampAcc(mAcc + mStep);
      else if (mPend[1] && !mPend[0]) mAcc <= clampAcc(mAcc - mStep);
      mPend <= (cmdWrEn ? cmdWrData : 3'b000) | {pinClear, pinDown, pinUp};
      if (fixedWrEn) mFix <= longint'($signed(fixedWrData));
      if (stepWrEn)  mStep <= longint'(stepWrData);
    end
  end

  task automatic check(string tag, longint act, longint exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Compare against the model on every falling edge
  always @(negedge clk) if (rstN && !finished) begin
    check("R4 pending", longint'(cmdPending), longint'(mPend));
    check("R10 incOffset", longint'($signed(incOffset)), mAcc);
    check("R11 total", longint'($signed(totalOffset)), mFix + mAcc);
  end

  task automatic writeCmd(logic [2:0] bits);
    cmdWrEn = 1; cmdWrData = bits;
    @(negedge clk); cmdWrEn = 0; cmdWrData = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 reset inc", longint'($signed(incOffset)), 0);
    check("R1 reset total", longint'($signed(totalOffset)), 0);
    check("R1 reset pending", longint'(cmdPending), 0);

    fixedWrEn = 1; fixedWrData = -40'sd5; stepWrEn = 1; stepWrData = 16'd100;
    @(negedge clk); fixedWrEn = 0; stepWrEn = 0;
    check("R2 fixed load", longint'($signed(totalOffset)), -5);

    cmdWrEn = 1; cmdWrData = 3'b001;
    @(negedge clk); cmdWrEn = 0;
    check("R4 pending set", longint'(cmdPending), 1);
    @(negedge clk);
    check("R4 self clear", longint'(cmdPending), 0);
    check("R3 step up", longint'($signed(incOffset)), 100);
    writeCmd(3'b001);
    check("R11 total sum", longint'($signed(totalOffset)), 195);
    writeCmd(3'b010);
    check("R5 step down", longint'($signed(incOffset)), 100);

    pinDown = 1; @(negedge clk); pinDown = 0; @(negedge clk);
    check("R8 pin down", longint'($signed(incOffset)), 0);
    pinUp = 1; cmdWrEn = 1; cmdWrData = 3'b001; @(negedge clk);
    pinUp = 0; cmdWrEn = 0; @(negedge clk);
    check("R8 pin or reg", longint'($signed(incOffset)), 100);

    writeCmd(3'b011);
    check("R9 cancel", longint'($signed(incOffset)), 100);
    writeCmd(3'b101);
    check("R9 clear wins", longint'($signed(incOffset)), 0);
    check("R6 fixed kept", longint'($signed(totalOffset)), -5);

    stepWrEn = 1; stepWrData = 16'hFFFF; @(negedge clk); stepWrEn = 0;
    for (int i = 0; i < 10; i++) writeCmd(3'b001);
    check("R10 top limit", longint'($signed(incOffset)), accHi);
    fixedWrEn = 1; fixedWrData = 40'sd7; @(negedge clk); fixedWrEn = 0;
    check("R7 fixed write keeps inc", longint'($signed(incOffset)), accHi);
    for (int i = 0; i < 20; i++) writeCmd(3'b010);
    check("R10 bottom limit", longint'($signed(incOffset)), accLo);
    pinClear = 1; @(negedge clk); pinClear = 0; @(negedge clk);
    check("R6 pin clear", longint'($signed(incOffset)), 0);

    for (int i = 0; i < 3000; i++) begin
      fixedWrEn = ($urandom_range(0, 19) == 0);
      fixedWrData = {$urandom(), $urandom()};
      stepWrEn = ($urandom_range(0, 15) == 0);
      stepWrData = 16'($urandom());
      cmdWrEn = ($urandom_range(0, 2) == 0);
      cmdWrData = 3'($urandom());
      if (cmdWrData[2] && $urandom_range(0, 3) != 0) cmdWrData[2] = 0;
      pinUp = ($urandom_range(0, 4) == 0);
      pinDown = ($urandom_range(0, 5) == 0);
      pinClear = ($urandom_range(0, 40) == 0);
      @(negedge clk);
    end
    {fixedWrEn, stepWrEn, cmdWrEn, pinUp, pinDown, pinClear} = '0;
    repeat (2) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule